// File: doc/BRIEF.md
# Integer Execute Unit with Operation Decoder

This block is the integer execute stage of a 32-bit load-store RISC core. It takes one fixed-format 32-bit instruction word and the two source register values read for it. It decodes the operation from the primary opcode, the function code and the shift-amount field. It then forms the second operand, either the second register value or an extended 16-bit constant, and returns a 32-bit result together with a zero flag.

The unit is purely combinational, and its outputs follow the inputs within the same cycle. Register-format instructions carry opcode 0 and select their operation with the function code in bits 5:0. Immediate forms are chosen by the opcode and take their constant from bits 15:0. An instruction word that the unit does not recognise produces a zero result and raises an illegal-operation flag, so that the surrounding pipeline can trap it. The block has no state and no modes, so it has neither states nor transitions.

Top module: `int_alu_unit`

## Requirements
- R1: With opcode 0 and function code 32, the result is rs + rt modulo 2^32, so 0xFFFFFFFF + 1 gives 0.
- R2: With opcode 0 and function code 34, the result is rs - rt modulo 2^32.
- R3: With opcode 0, function code 36 gives rs AND rt, 37 gives rs OR rt, and 39 gives NOT(rs OR rt). NOR with a zero operand therefore yields the bitwise inverse.
- R4: With opcode 0, function code 0 shifts rt left and function code 2 shifts rt right, in both cases by instr[10:6] positions with zero fill. The rs value has no effect on these shifts.
- R5: With opcode 0 and function code 42, the result is 1 when rs < rt as signed two's-complement values and 0 otherwise.
- R6: With opcode 0 and function code 43, the result is 1 when rs < rt as unsigned values and 0 otherwise.
- R7: Opcode 8 returns rs plus the sign-extended instr[15:0]. The rt value has no effect.
- R8: Opcode 10 compares rs with the sign-extended instr[15:0] as signed values. Opcode 11 compares rs with the same sign-extended constant as unsigned values. Both give 1 if rs is less and 0 otherwise.
- R9: Opcode 12 returns rs AND the zero-extended instr[15:0], and opcode 13 returns rs OR the zero-extended instr[15:0].
- R10: Opcode 15 returns instr[15:0] in bits 31:16 with bits 15:0 cleared. The rs and rt values have no effect.
- R11: zero_o is 1 exactly when result_o equals 0.
- R12: The legal opcodes are 0, 8, 10, 11, 12, 13 and 15. With opcode 0, the legal function codes are 0, 2, 32, 34, 36, 37, 39, 42 and 43. Any other opcode, or any other function code under opcode 0, drives result_o to 0 and illegal_o to 1. Every legal combination drives illegal_o to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| instr_i | input | 32 | Instruction word: opcode [31:26], shift amount [10:6], function [5:0], constant [15:0] |
| rs_val_i | input | 32 | First source register value |
| rt_val_i | input | 32 | Second source register value |
| result_o | output | 32 | Operation result |
| zero_o | output | 1 | High when the result is zero |
| illegal_o | output | 1 | High for an unrecognised opcode or function code |

## Verification
The in-line checks are immediate assertions inside combinational processes. They assume that the instruction word and both operands are known values and stay stable until the decoder, the operand selector and the core have settled. The bench drives all three inputs together in one task, shortly after a rising edge, and only ever applies fully defined values. It samples the outputs at the following falling edge, well after everything has settled. The bench also sweeps every opcode and every function code under opcode 0, so the illegal-detection logic sees the full encoding space.

// File: rtl/ialu_pkg.sv
package ialu_pkg;
    localparam int OPC_W = 6;
    localparam int FN_W  = 6;
    localparam int SH_W  = 5;
    localparam int IMM_W = 16;

    localparam logic [OPC_W-1:0] OPC_REG   = 6'd0;
    localparam logic [OPC_W-1:0] OPC_ADDI  = 6'd8;
    localparam logic [OPC_W-1:0] OPC_SLTI  = 6'd10;
    localparam logic [OPC_W-1:0] OPC_SLTIU = 6'd11;
    localparam logic [OPC_W-1:0] OPC_ANDI  = 6'd12;
    localparam logic [OPC_W-1:0] OPC_ORI   = 6'd13;
    localparam logic [OPC_W-1:0] OPC_LUI   = 6'd15;

    localparam logic [FN_W-1:0] FN_SLL  = 6'd0;
    localparam logic [FN_W-1:0] FN_SRL  = 6'd2;
    localparam logic [FN_W-1:0] FN_ADD  = 6'd32;
    localparam logic [FN_W-1:0] FN_SUB  = 6'd34;
    localparam logic [FN_W-1:0] FN_AND  = 6'd36;
    localparam logic [FN_W-1:0] FN_OR   = 6'd37;
    localparam logic [FN_W-1:0] FN_NOR  = 6'd39;
    localparam logic [FN_W-1:0] FN_SLT  = 6'd42;
    localparam logic [FN_W-1:0] FN_SLTU = 6'd43;

    typedef enum logic [3:0] {
        OP_NONE,
        OP_ADD,
        OP_SUB,
        OP_AND,
        OP_OR,
        OP_NOR,
        OP_SLL,
        OP_SRL,
        OP_SLT,
        OP_SLTU,
        OP_LUI
    } alu_op_e;

    typedef enum logic [1:0] {
        BSEL_REG,
        BSEL_SEXT,
        BSEL_ZEXT
    } bsel_e;
endpackage

// File: rtl/ialu_decode.sv
module ialu_decode
    import ialu_pkg::*;
(
    input  logic [OPC_W-1:0] opc_i,
    input  logic [FN_W-1:0]  funct_i,
    output alu_op_e          op_o,
    output bsel_e            bsel_o,
    output logic             illegal_o
);
    alu_op_e op_c;
    bsel_e   bsel_c;
    logic    bad_c;

    always_comb begin
        op_c   = OP_NONE;
        bsel_c = BSEL_REG;
        bad_c  = 1'b0;
        case (opc_i)
            OPC_REG: begin
                case (funct_i)
                    FN_SLL:  op_c = OP_SLL;
                    FN_SRL:  op_c = OP_SRL;
                    FN_ADD:  op_c = OP_ADD;
                    FN_SUB:  op_c = OP_SUB;
                    FN_AND:  op_c = OP_AND;
                    FN_OR:   op_c = OP_OR;
                    FN_NOR:  op_c = OP_NOR;
                    FN_SLT:  op_c = OP_SLT;
                    FN_SLTU: op_c = OP_SLTU;
                    default: bad_c = 1'b1;
                endcase
            end
            OPC_ADDI:  begin op_c = OP_ADD;  bsel_c = BSEL_SEXT; end
            OPC_SLTI:  begin op_c = OP_SLT;  bsel_c = BSEL_SEXT; end
            OPC_SLTIU: begin op_c = OP_SLTU; bsel_c = BSEL_SEXT; end
            OPC_ANDI:  begin op_c = OP_AND;  bsel_c = BSEL_ZEXT; end
            OPC_ORI:   begin op_c = OP_OR;   bsel_c = BSEL_ZEXT; end
            OPC_LUI:   begin op_c = OP_LUI;  bsel_c = BSEL_ZEXT; end
            default:   bad_c = 1'b1;
        endcase
        // R12: a flagged instruction never carries a live operation
        p_illegal_no_op_r12: assert (!bad_c || op_c == OP_NONE)
            else $error("illegal decode selected an operation");
    end

    assign op_o      = op_c;
    assign bsel_o    = bsel_c;
    assign illegal_o = bad_c;
endmodule

// File: rtl/ialu_operand.sv
module ialu_operand
    import ialu_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0] rt_val_i,
    input  logic [IMM_W-1:0]  imm_i,
    input  bsel_e             bsel_i,
    output logic [DATA_W-1:0] b_o
);
    localparam int EXT_W = DATA_W - IMM_W;

    logic [DATA_W-1:0] sext_w;
    logic [DATA_W-1:0] zext_w;

    assign sext_w = {{EXT_W{imm_i[IMM_W-1]}}, imm_i};
    assign zext_w = {{EXT_W{1'b0}}, imm_i};

    always_comb begin
        unique case (bsel_i)
            BSEL_SEXT: b_o = sext_w;
            BSEL_ZEXT: b_o = zext_w;
            default:   b_o = rt_val_i;
        endcase
    end
endmodule

// File: rtl/ialu_core.sv
module ialu_core
    import ialu_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  alu_op_e           op_i,
    input  logic [DATA_W-1:0] a_i,
    input  logic [DATA_W-1:0] b_i,
    input  logic [SH_W-1:0]   shamt_i,
    output logic [DATA_W-1:0] result_o
);
    logic [DATA_W-1:0] res_c;

    always_comb begin
        res_c = '0;
        case (op_i)
            OP_ADD:  res_c = a_i + b_i;
            OP_SUB:  res_c = a_i - b_i;
            OP_AND:  res_c = a_i & b_i;
            OP_OR:   res_c = a_i | b_i;
            OP_NOR:  res_c = ~(a_i | b_i);
            OP_SLL:  res_c = b_i << shamt_i;
            OP_SRL:  res_c = b_i >> shamt_i;
            OP_SLT:  res_c = {{(DATA_W-1){1'b0}}, ($signed(a_i) < $signed(b_i))};
            OP_SLTU: res_c = {{(DATA_W-1){1'b0}}, (a_i < b_i)};
            OP_LUI:  res_c = b_i << IMM_W;
            default: res_c = '0;
        endcase
        // R5 R6: comparisons yield a single-bit truth value
        p_slt_boolean_r5: assert (!(op_i == OP_SLT || op_i == OP_SLTU) || res_c[DATA_W-1:1] == '0)
            else $error("set-less-than produced more than one bit");
        // R10: upper-immediate leaves the low half clear
        p_lui_low_clear_r10: assert (op_i != OP_LUI || res_c[IMM_W-1:0] == '0)
            else $error("upper-immediate low half not clear");
        // R2: subtracting equal operands gives zero
        p_sub_self_zero_r2: assert (!(op_i == OP_SUB && a_i == b_i) || res_c == '0)
            else $error("equal-operand subtract not zero");
        // R4: a shift by zero passes the operand through
        p_shift_zero_pass_r4: assert (!((op_i == OP_SLL || op_i == OP_SRL) && shamt_i == '0) || res_c == b_i)
            else $error("zero shift altered operand");
        // R12: no operation selected gives a zero result
        p_none_zero_r12: assert (op_i != OP_NONE || res_c == '0)
            else $error("unselected operation gave nonzero result");
    end

    assign result_o = res_c;
endmodule

// File: rtl/int_alu_unit.sv
module int_alu_unit
    import ialu_pkg::*;
#(
    parameter int DATA_W  = 32,
    parameter int INSTR_W = 32
) (
    input  logic [INSTR_W-1:0] instr_i,
    input  logic [DATA_W-1:0]  rs_val_i,
    input  logic [DATA_W-1:0]  rt_val_i,
    output logic [DATA_W-1:0]  result_o,
    output logic               zero_o,
    output logic               illegal_o
);
    localparam int OPC_LSB = INSTR_W - OPC_W;
    localparam int SH_LSB  = FN_W;

    alu_op_e           op_w;
    bsel_e             bsel_w;
    logic [DATA_W-1:0] b_w;
    logic [DATA_W-1:0] res_w;

    ialu_decode u_decode (
        .opc_i     (instr_i[INSTR_W-1:OPC_LSB]),
        .funct_i   (instr_i[FN_W-1:0]),
        .op_o      (op_w),
        .bsel_o    (bsel_w),
        .illegal_o (illegal_o)
    );

    ialu_operand #(.DATA_W(DATA_W)) u_operand (
        .rt_val_i (rt_val_i),
        .imm_i    (instr_i[IMM_W-1:0]),
        .bsel_i   (bsel_w),
        .b_o      (b_w)
    );

    ialu_core #(.DATA_W(DATA_W)) u_core (
        .op_i     (op_w),
        .a_i      (rs_val_i),
        .b_i      (b_w),
        .shamt_i  (instr_i[SH_LSB+SH_W-1:SH_LSB]),
        .result_o (res_w)
    );

    assign result_o = res_w;
    assign zero_o   = (res_w == '0);
endmodule

// File: tb/int_alu_unit_tb_top.sv
module int_alu_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] instr;
    logic [31:0] rs_val;
    logic [31:0] rt_val;
    logic [31:0] result;
    logic        zero;
    logic        illegal;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    always #5 clk = ~clk;

    int_alu_unit dut_i (
        .instr_i   (instr),
        .rs_val_i  (rs_val),
        .rt_val_i  (rt_val),
        .result_o  (result),
        .zero_o    (zero),
        .illegal_o (illegal)
    );

    typedef struct packed {
        logic [31:0] ins;
        logic [31:0] a;
        logic [31:0] b;
        logic [31:0] res;
        logic        z;
        logic        ill;
        logic [7:0]  req;
    } vec_t;

    function automatic logic [31:0] rfmt(input logic [4:0] sh, input logic [5:0] fn);
        return {6'd0, 15'd0, sh, fn};
    endfunction

    function automatic logic [31:0] ifmt(input logic [5:0] opc, input logic [15:0] imm);
        return {opc, 10'd0, imm};
    endfunction

    localparam int NV = 27;
    localparam vec_t VECS [NV] = '{
        '{rfmt(0, 32), 32'd5, 32'd7, 32'd12, 1'b0, 1'b0, 8'd1},                             // R1
        '{rfmt(0, 32), 32'hFFFFFFFF, 32'd1, 32'd0, 1'b1, 1'b0, 8'd1},                       // R1 wrap, R11
        '{rfmt(0, 34), 32'd10, 32'd3, 32'd7, 1'b0, 1'b0, 8'd2},                             // R2
        '{rfmt(0, 34), 32'd3, 32'd10, 32'hFFFFFFF9, 1'b0, 1'b0, 8'd2},                      // R2
        '{rfmt(0, 36), 32'h00000DC0, 32'h00003C00, 32'h00000C00, 1'b0, 1'b0, 8'd3},         // R3 and
        '{rfmt(0, 37), 32'h00000DC0, 32'h00003C00, 32'h00003DC0, 1'b0, 1'b0, 8'd3},         // R3 or
        '{rfmt(0, 39), 32'h00003C00, 32'h0, 32'hFFFFC3FF, 1'b0, 1'b0, 8'd3},                // R3 nor as not
        '{rfmt(4, 0), 32'hDEADBEEF, 32'h9, 32'h90, 1'b0, 1'b0, 8'd4},                       // R4 sll
        '{rfmt(31, 2), 32'hDEADBEEF, 32'h80000000, 32'h1, 1'b0, 1'b0, 8'd4},                // R4 srl
        '{rfmt(0, 0), 32'hFFFFFFFF, 32'h12345678, 32'h12345678, 1'b0, 1'b0, 8'd4},          // R4 zero shift
        '{rfmt(8, 2), 32'h0, 32'h0000FF00, 32'h000000FF, 1'b0, 1'b0, 8'd4},                 // R4 srl fill
        '{rfmt(0, 42), 32'hFFFFFFFF, 32'h0, 32'h1, 1'b0, 1'b0, 8'd5},                       // R5
        '{rfmt(0, 42), 32'h0, 32'hFFFFFFFF, 32'h0, 1'b1, 1'b0, 8'd5},                       // R5
        '{rfmt(0, 43), 32'hFFFFFFFF, 32'h0, 32'h0, 1'b1, 1'b0, 8'd6},                       // R6
        '{rfmt(0, 43), 32'h0, 32'hFFFFFFFF, 32'h1, 1'b0, 1'b0, 8'd6},                       // R6
        '{ifmt(8, 16'hFFFF), 32'd5, 32'h100, 32'd4, 1'b0, 1'b0, 8'd7},                      // R7
        '{ifmt(8, 16'h7FFF), 32'd1, 32'h100, 32'h8000, 1'b0, 1'b0, 8'd7},                   // R7
        '{ifmt(10, 16'hFFFF), 32'hFFFFFFFE, 32'h0, 32'h1, 1'b0, 1'b0, 8'd8},                // R8 slti
        '{ifmt(11, 16'hFFFF), 32'd5, 32'h0, 32'h1, 1'b0, 1'b0, 8'd8},                       // R8 sltiu
        '{ifmt(11, 16'h0004), 32'd5, 32'h0, 32'h0, 1'b1, 1'b0, 8'd8},                       // R8 sltiu
        '{ifmt(12, 16'hF0F0), 32'hFFFFFFFF, 32'h0, 32'h0000F0F0, 1'b0, 1'b0, 8'd9},         // R9 andi
        '{ifmt(13, 16'h8001), 32'h12340000, 32'h0, 32'h12348001, 1'b0, 1'b0, 8'd9},         // R9 ori
        '{ifmt(15, 16'h1234), 32'hFFFFFFFF, 32'hFFFFFFFF, 32'h12340000, 1'b0, 1'b0, 8'd10}, // R10
        '{ifmt(15, 16'h0000), 32'hFFFFFFFF, 32'h1, 32'h0, 1'b1, 1'b0, 8'd10},               // R10, R11
        '{rfmt(0, 1), 32'd5, 32'd5, 32'h0, 1'b1, 1'b1, 8'd12},                              // R12 funct
        '{ifmt(4, 16'h0001), 32'd5, 32'd5, 32'h0, 1'b1, 1'b1, 8'd12},                       // R12 opcode
        '{ifmt(63, 16'hFFFF), 32'd7, 32'd9, 32'h0, 1'b1, 1'b1, 8'd12}                       // R12 opcode
    };

    task automatic drive(input logic [31:0] ins, input logic [31:0] a, input logic [31:0] b);
        @(posedge clk);
        #1;
        instr  = ins;
        rs_val = a;
        rt_val = b;
        @(negedge clk);
    endtask

    task automatic check(input string tag, input logic [31:0] er, input logic ez, input logic ei);
        n_checks++;
        if (result !== er || zero !== ez || illegal !== ei) begin
            n_fails++;
            $display("FAIL %s: result=%h zero=%b illegal=%b expected result=%h zero=%b illegal=%b",
                     tag, result, zero, illegal, er, ez, ei);
        end
    endtask

    function automatic bit opc_legal(input int o);
        return o == 0 || o == 8 || o == 10 || o == 11 || o == 12 || o == 13 || o == 15;
    endfunction

    function automatic bit fn_legal(input int f);
        return f == 0 || f == 2 || f == 32 || f == 34 || f == 36 || f == 37 ||
               f == 39 || f == 42 || f == 43;
    endfunction

    initial begin
        instr  = 32'h0;
        rs_val = 32'h0;
        rt_val = 32'h0;
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11 R4: idle all-zero word is a zero shift of zero
        check("R11 reset state", 32'h0, 1'b1, 1'b0);

        for (int i = 0; i < NV; i++) begin
            drive(VECS[i].ins, VECS[i].a, VECS[i].b);
            check($sformatf("R%0d vector %0d", VECS[i].req, i), VECS[i].res, VECS[i].z, VECS[i].ill);
        end

        // R12: sweep every opcode with a non-opcode-0 friendly constant
        for (int o = 1; o < 64; o++) begin
            logic [31:0] er;
            bit lg;
            lg = opc_legal(o);
            drive({o[5:0], 10'd0, 16'h0003}, 32'h00000010, 32'h0);
            case (o)
                8:       er = 32'h13;
                10:      er = 32'h0;
                11:      er = 32'h0;
                12:      er = 32'h0;
                13:      er = 32'h13;
                15:      er = 32'h00030000;
                default: er = 32'h0;
            endcase
            check($sformatf("R12 opcode sweep %0d", o), er, (er == 0), !lg);
        end

        // R12: sweep every function code under opcode 0
        for (int f = 0; f < 64; f++) begin
            drive(rfmt(5'd0, f[5:0]), 32'h5, 32'h5);
            if (!fn_legal(f))
                check($sformatf("R12 funct sweep %0d", f), 32'h0, 1'b1, 1'b1);
            else begin
                n_checks++;
                if (illegal !== 1'b0) begin
                    n_fails++;
                    $display("FAIL R12 funct %0d: illegal=%b expected 0", f, illegal);
                end
            end
        end

        // R11: a nonzero result holds the zero flag low
        drive(rfmt(0, 37), 32'h80000000, 32'h0);
        check("R11 msb only", 32'h80000000, 1'b0, 1'b0);

        // R3: NOR of all ones gives zero
        drive(rfmt(0, 39), 32'hFFFFFFFF, 32'h0);
        check("R3 nor all ones", 32'h0, 1'b1, 1'b0);

        // R5: most negative against most positive
        drive(rfmt(0, 42), 32'h80000000, 32'h7FFFFFFF);
        check("R5 extremes", 32'h1, 1'b0, 1'b0);
        // R6: same bits unsigned
        drive(rfmt(0, 43), 32'h80000000, 32'h7FFFFFFF);
        check("R6 extremes", 32'h0, 1'b1, 1'b0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end
endmodule